// File: doc/BRIEF.md
# Slave-Clocked Serial Audio Transmitter

This block sends 16-bit audio samples over an I2S-style serial link on which an external codec owns both the bit clock and the left/right word-select line. It runs on one system clock. It synchronises the two incoming clock lines into that clock and sees their edges there. It shifts each sample out MSB first, one word per half of the word-select period. The first bit appears one bit period after the word-select transition.

Samples arrive on a ready/valid port and wait in a one-word holding register, so the next sample can be accepted while the current one is still on the wire. After it is enabled, the block sends nothing until it sees word-select rise. That edge means the codec is in a right half. At that edge the block pulses `sync_o` once. The first word goes out in the next left half, so left/right order is always correct. In stereo mode every word-select edge starts a slot. In mono mode only falling edges start a slot, and words appear only in left halves. A slot that should carry a sample but finds none sends zeros and raises a sticky underrun flag.

Top module: `i2s_slave_tx`

## Requirements
- R1: After reset, `sd_o`, `s_ready_o`, `sync_o` and `underrun_o` are all 0.
- R2: A word is sent MSB first, 16 bits, with one bit per bit-clock period. `sd_o` changes after falling edges of `bclk_i`, and the receiver samples it on rising edges. The MSB is valid at the first rising edge of `bclk_i` after the one at which a `ws_i` change is first seen.
- R3: `ws_i` low is the left slot and `ws_i` high is the right slot. After enable, no word is sent until a `ws_i` rising edge is seen. The slot in which that rise happens is right and carries zeros. The first word goes into the following left slot.
- R4: `sync_o` is a single-cycle pulse. It appears exactly once per enable period, when that first `ws_i` rise is detected.
- R5: In stereo mode (`mono_i`=0), successive words go into successive slots, alternating left, right, left and so on.
- R6: In mono mode (`mono_i`=1), words go only into left slots. Right slots carry all zeros, take no word from the holding register and never set the underrun flag.
- R7: If a slot that should carry a word starts with no word available, it carries all zeros and `underrun_o` is set. The flag stays set until `underrun_clr_i` is high for a cycle. If setting and clearing fall in the same cycle, setting wins.
- R8: While enabled, `s_ready_o` is high exactly when the holding register is empty. A new word can be accepted while the previous one is shifting out.
- R9: A slot loads its word on the third `clk_i` rising edge after `bclk_i` falls. A word handed over on that same edge while the holding register is empty goes into that slot, and no underrun is flagged.
- R10: While `en_i` is low, `sd_o` is low from the next cycle on and `s_ready_o` is low. Any held word is dropped. On re-enable, the block again waits for a `ws_i` rise (R3, R4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable; low flushes the block and returns it to waiting for a word-select rise |
| mono_i | input | 1 | 1: words in left slots only; 0: words in both slots |
| bclk_i | input | 1 | Bit clock from the codec |
| ws_i | input | 1 | Word select from the codec; low = left, high = right |
| sd_o | output | 1 | Serial data |
| s_valid_i | input | 1 | Sample word valid |
| s_data_i | input | WORD_W | Sample word |
| s_ready_o | output | 1 | Holding register can accept a word |
| sync_o | output | 1 | One-cycle pulse on the first word-select rise after enable |
| underrun_o | output | 1 | Sticky: a slot found no word |
| underrun_clr_i | input | 1 | Clears `underrun_o` |

## Verification
Two things can fall in the same cycle: a slot loading its word and a new word arriving at an empty holding register. If the two were handled in the wrong order, the slot would go out as zeros with an underrun and the word would slip to a later slot. The bench forces the coincidence in mono mode after the supply has run dry. It hands over a word exactly on the third system-clock edge after the bit clock falls at the start of a left slot. It then checks that the received left word equals that sample and that the underrun flag, cleared beforehand, is still clear once the following right slot has begun.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
  typedef enum logic {
    ST_WAIT_RISE = 1'b0,
    ST_RUN       = 1'b1
  } tx_state_e;
endpackage

// File: rtl/i2s_tx_edge.sv
module i2s_tx_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_i,
  input  logic ws_i,
  output logic bclk_fall_o,
  output logic ws_rise_o,
  output logic ws_fall_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] bclk_sr, ws_sr;
  logic bclk_d, ws_q, bclk_s, ws_s, bclk_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_sr <= '0;
      ws_sr   <= '0;
    end else begin
      bclk_sr <= {bclk_sr[LAST-1:0], bclk_i};
      ws_sr   <= {ws_sr[LAST-1:0], ws_i};
    end
  end

  assign bclk_s = bclk_sr[LAST];
  assign ws_s   = ws_sr[LAST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_d <= 1'b0;
      ws_q   <= 1'b0;
    end else begin
      bclk_d <= bclk_s;
      if (bclk_rise) ws_q <= ws_s;  // word select sampled on bit-clock rise
    end
  end

  assign bclk_rise   = bclk_s & ~bclk_d;
  assign bclk_fall_o = ~bclk_s & bclk_d;
  assign ws_rise_o   = bclk_rise & ws_s & ~ws_q;
  assign ws_fall_o   = bclk_rise & ~ws_s & ws_q;
endmodule

// File: rtl/i2s_tx_hold.sv
module i2s_tx_hold #(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              in_valid_i,
  input  logic [WORD_W-1:0] in_data_i,
  output logic              in_ready_o,
  input  logic              take_i,
  output logic              out_valid_o,
  output logic [WORD_W-1:0] out_data_o
);
  logic              full_q;
  logic [WORD_W-1:0] data_q;
  logic              in_fire;

  assign in_ready_o  = en_i & ~full_q;
  assign in_fire     = in_valid_i & in_ready_o;
  // bypass: a word arriving in the load cycle feeds the slot directly
  assign out_valid_o = full_q | in_fire;
  assign out_data_o  = full_q ? data_q : in_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (!en_i) begin
      full_q <= 1'b0;
    end else if (take_i) begin
      full_q <= 1'b0;
    end else if (in_fire) begin
      full_q <= 1'b1;
      data_q <= in_data_i;
    end
  end
endmodule

// File: rtl/i2s_tx_shift.sv
module i2s_tx_shift #(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_data_i,
  input  logic              shift_i,
  output logic              sd_o
);
  logic [WORD_W-1:0] sreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sreg_q <= '0;
    else if (clear_i) sreg_q <= '0;
    else if (load_i)  sreg_q <= load_data_i;
    else if (shift_i) sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
  end

  assign sd_o = sreg_q[WORD_W-1];
endmodule

// File: rtl/i2s_slave_tx.sv
module i2s_slave_tx
  import i2s_tx_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              mono_i,
  input  logic              bclk_i,
  input  logic              ws_i,
  output logic              sd_o,
  input  logic              s_valid_i,
  input  logic [WORD_W-1:0] s_data_i,
  output logic              s_ready_o,
  output logic              sync_o,
  output logic              underrun_o,
  input  logic              underrun_clr_i
);
  tx_state_e state_q;
  logic bclk_fall, ws_rise, ws_fall;
  logic pend_q, pend_use_q;
  logic load, take, hold_valid;
  logic [WORD_W-1:0] hold_data, load_data;
  logic sync_q, underrun_q;

  i2s_tx_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bclk_i     (bclk_i),
    .ws_i       (ws_i),
    .bclk_fall_o(bclk_fall),
    .ws_rise_o  (ws_rise),
    .ws_fall_o  (ws_fall)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_WAIT_RISE;
      pend_q     <= 1'b0;
      pend_use_q <= 1'b0;
      sync_q     <= 1'b0;
    end else if (!en_i) begin
      state_q    <= ST_WAIT_RISE;
      pend_q     <= 1'b0;
      pend_use_q <= 1'b0;
      sync_q     <= 1'b0;
    end else begin
      sync_q <= (state_q == ST_WAIT_RISE) && ws_rise;
      if (state_q == ST_WAIT_RISE) begin
        if (ws_rise) state_q <= ST_RUN;  // the slot now starting is right: skip it
      end else if (ws_rise || ws_fall) begin
        pend_q     <= 1'b1;
        pend_use_q <= mono_i ? ws_fall : 1'b1;
      end else if (bclk_fall && pend_q) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign load      = bclk_fall & pend_q;
  assign take      = load & pend_use_q;
  assign load_data = (take && hold_valid) ? hold_data : '0;

  i2s_tx_hold #(.WORD_W(WORD_W)) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .in_valid_i (s_valid_i),
    .in_data_i  (s_data_i),
    .in_ready_o (s_ready_o),
    .take_i     (take),
    .out_valid_o(hold_valid),
    .out_data_o (hold_data)
  );

  i2s_tx_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (~en_i),
    .load_i     (load),
    .load_data_i(load_data),
    .shift_i    (bclk_fall & ~pend_q),
    .sd_o       (sd_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  underrun_q <= 1'b0;
    else if (take && !hold_valid) underrun_q <= 1'b1;
    else if (underrun_clr_i)      underrun_q <= 1'b0;
  end

  assign sync_o     = sync_q;
  assign underrun_o = underrun_q;
endmodule

// File: rtl/i2s_slave_tx_chk.sv
module i2s_slave_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic sd_o,
  input logic s_ready_o,
  input logic sync_o,
  input logic underrun_o,
  input logic underrun_clr_i
);
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     seen_q <= 1'b0;
    else if (!en_i)  seen_q <= 1'b0;
    else if (sync_o) seen_q <= 1'b1;
  end

  assert_sd_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !sd_o);
  assert_ready_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !s_ready_o);
  assert_sync_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |=> !sync_o);
  assert_sync_once_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_o && en_i) |-> !seen_q);
  assert_underrun_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_o && !underrun_clr_i) |=> underrun_o);
  assert_underrun_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(underrun_o) |-> $past(underrun_clr_i));
endmodule

bind i2s_slave_tx i2s_slave_tx_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .en_i          (en_i),
  .sd_o          (sd_o),
  .s_ready_o     (s_ready_o),
  .sync_o        (sync_o),
  .underrun_o    (underrun_o),
  .underrun_clr_i(underrun_clr_i)
);

// File: tb/i2s_slave_tx_tb_top.sv
module i2s_slave_tx_tb_top;
  localparam int W = 16;
  localparam int NSLOT = 512;
  // {mono, word}
  localparam logic [16:0] VEC [10] = '{
    17'h0A5C3, 17'h01234, 17'h08001, 17'h07FFE, 17'h0F00F, 17'h00F0F,
    17'h14B1D, 17'h1E3E3, 17'h10001, 17'h19AB7
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, en = 1'b0, mono = 1'b0, bclk = 1'b1, ws = 1'b1;
  logic s_valid = 1'b0, clr = 1'b0;
  logic [W-1:0] s_data = '0;
  logic sd, s_ready, sync_p, underrun;

  i2s_slave_tx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .mono_i(mono), .bclk_i(bclk), .ws_i(ws),
    .sd_o(sd), .s_valid_i(s_valid), .s_data_i(s_data), .s_ready_o(s_ready),
    .sync_o(sync_p), .underrun_o(underrun), .underrun_clr_i(clr)
  );

  int total = 0, bad = 0;
  int gen_ws = 1, gen_bit = 0;
  int rx_idx = 0, rx_cnt = 0, sync_cnt = 0, sync_slot = 0;
  logic [W-1:0] rx_word [NSLOT];
  logic         rx_ch   [NSLOT];
  logic [W-1:0] rx_sh = '0;
  logic         ws_prev = 1'b1;
  event ev_lfall1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // codec model: 8 clk per bit, 16 bits per slot; also a bit-level receiver
  initial begin
    for (int i = 0; i < NSLOT; i++) begin
      rx_word[i] = '0;
      rx_ch[i]   = 1'b0;
    end
    forever begin
      for (int h = 0; h < 2; h++) begin
        for (int b = 0; b < 16; b++) begin
          @(negedge clk);
          bclk = 1'b0;
          if (b == 0) ws = h[0];
          gen_ws = h; gen_bit = b;
          if (h == 0 && b == 1) ->ev_lfall1;
          repeat (4) @(negedge clk);
          bclk = 1'b1;
          if (rx_cnt >= 1 && rx_cnt <= 16) begin
            rx_sh = {rx_sh[W-2:0], sd};
            if (rx_cnt == 16 && rx_idx < NSLOT) rx_word[rx_idx] = rx_sh;
          end
          if (ws != ws_prev) begin
            rx_idx++;
            if (rx_idx < NSLOT) rx_ch[rx_idx] = ws;
            rx_cnt = 1;
          end else if (rx_cnt < 20) begin
            rx_cnt++;
          end
          ws_prev = ws;
          repeat (3) @(negedge clk);
        end
      end
    end
  end

  always @(negedge clk) if (sync_p) begin
    sync_cnt++;
    sync_slot = rx_idx;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    summary();
  end

  task automatic push(input logic [W-1:0] d);
    @(negedge clk);
    while (!s_ready) @(negedge clk);
    s_valid = 1'b1; s_data = d;
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic wait_pos(input int h, input int b);
    @(negedge clk);
    while (!(gen_ws == h && gen_bit == b)) @(negedge clk);
  endtask

  task automatic run_phase(input int lo, input int hi, input int en_half);
    bit m;
    m = VEC[lo][16];
    en = 1'b0;
    repeat (3) @(negedge clk);
    mono = m;
    wait_pos(en_half, 4);
    sync_cnt = 0;
    en = 1'b1;
    @(negedge clk);
    chk(s_ready == 1'b1, "R8 ready when empty", s_ready, 1);
    for (int r = lo; r <= hi; r++) push(VEC[r][15:0]);
    chk(underrun == 1'b0, "R7 no underrun while fed", underrun, 0);
    repeat (768) @(negedge clk);
    chk(sync_cnt == 1, "R4 single sync pulse", sync_cnt, 1);
    chk(rx_ch[sync_slot] == 1'b1, "R3 sync in right slot", rx_ch[sync_slot], 1);
    chk(rx_word[sync_slot] == '0, "R3 nothing before left", rx_word[sync_slot], 0);
    for (int k = 0; k <= hi - lo; k++) begin
      int s;
      s = sync_slot + 1 + (m ? 2 * k : k);
      chk(rx_word[s] == VEC[lo+k][15:0], m ? "R6 R2 mono word" : "R5 R2 stereo word",
          rx_word[s], VEC[lo+k][15:0]);
      chk(rx_ch[s] == (m ? 1'b0 : k[0]), m ? "R6 left only" : "R3 R5 slot order",
          rx_ch[s], m ? 0 : k % 2);
      if (m) chk(rx_word[s+1] == '0, "R6 right slot zero", rx_word[s+1], 0);
    end
    chk(underrun == 1'b1, "R7 underrun after supply ends", underrun, 1);
    wait_pos(0, 8);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk(underrun == 1'b0, "R7 clear", underrun, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(sd == 1'b0, "R1 sd reset", sd, 0);
    chk(s_ready == 1'b0, "R1 ready reset", s_ready, 0);
    chk(sync_p == 1'b0, "R1 sync reset", sync_p, 0);
    chk(underrun == 1'b0, "R1 underrun reset", underrun, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    run_phase(0, 5, 0);   // stereo, enabled inside a left slot
    run_phase(6, 9, 1);   // mono, enabled inside a right slot

    // R9: word handed over on the very load edge of a left slot
    begin
      int exp_slot;
      @(ev_lfall1);
      repeat (2) @(negedge clk);
      s_valid = 1'b1; s_data = 16'h3C5A;
      exp_slot = rx_idx;
      @(negedge clk);
      s_valid = 1'b0;
      wait_pos(1, 8);
      chk(rx_word[exp_slot] == 16'h3C5A, "R9 coincident word sent", rx_word[exp_slot], 16'h3C5A);
      chk(underrun == 1'b0, "R9 R6 no underrun", underrun, 0);
    end

    // R10: disable mid-word, then re-enable
    mono = 1'b0;
    push(16'hFFFF);
    begin
      int n;
      n = 0;
      while (sd !== 1'b1 && n < 2000) begin
        @(negedge clk);
        n++;
      end
      chk(sd == 1'b1, "R2 word starts", sd, 1);
    end
    push(16'h8001);
    chk(s_ready == 1'b0, "R8 second word held", s_ready, 0);
    en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(sd == 1'b0, "R10 sd low", sd, 0);
    chk(s_ready == 1'b0, "R10 ready low", s_ready, 0);
    sync_cnt = 0;
    en = 1'b1;
    @(negedge clk);
    chk(s_ready == 1'b1, "R10 held word dropped", s_ready, 1);
    repeat (768) @(negedge clk);
    chk(sync_cnt == 1, "R10 R4 resync", sync_cnt, 1);

    summary();
  end
endmodule